// File: doc/BRIEF.md
# Byte-Enabled ECC-Protected Memory

This block is a word-wide storage array of 32-bit words. Each word is kept together with seven check bits: six Hamming bits and one parity bit over the whole codeword. Every write encodes the word before it is stored. Every read decodes the stored codeword and repairs any single flipped bit before the data reaches the outputs. Writes and reads work per byte lane, so a host can update or fetch any subset of the four bytes of a word.

The block is selected only when three active-low chip selects are all asserted. A clocked write stores the word when the write enable is low. A read is combinational while the output enable is low and the write enable is high. A partial write first repairs the stored word, then merges in the new bytes and re-encodes the result. When a read repairs a word, an error flag goes high for as long as that read lasts. The repaired word is not written back to the array. A fault-injection port exists for test. It flips one stored bit so that the repair path can be exercised. The array holds `2**DEPTH_LOG2` words. Address values beyond that depth are treated as not selected.

Top module: `ecc_mem`

## Requirements
- R1: A write or read happens only when `cs1_n`, `cs2_n` and `cs3_n` are all low. With any of them high, nothing is stored, `dout_oe` is 0 and `err` is low.
- R2: A selected write with `we_n` low and `be_n`=4'b0000 stores `din` at the rising clock edge. A later full read of that address returns the same word with `err` low.
- R3: `be_n[0]`, `be_n[1]`, `be_n[2]` and `be_n[3]` (active low) select data bits 7:0, 15:8, 23:16 and 31:24. A write changes only the enabled bytes and leaves the others at their stored values.
- R4: During a read, `dout_oe[i]` is 1 exactly for the lanes with `be_n[i]` low. Every lane whose `dout_oe` bit is 0 reads as zero on `dout`.
- R5: `dout_oe` is 4'b0000 while `oe_n` is high, while all four byte enables are high, or while a write is active (`we_n` low).
- R6: A single flipped bit in any of the 39 stored bits is corrected on read. Index 0-31 is data bit 0-31, 32-37 are Hamming bits and 38 is the overall parity. `err` is high during that read.
- R7: `err` is low on reads of clean words and at all times when no read is active.
- R8: A corrected word is not written back. Reading it again raises `err` again, until a full write replaces it.
- R9: A partial write into a word with a single flipped bit stores the repaired old bytes merged with the new bytes. A later full read returns that merged word with `err` low.
- R10: Two flipped data bits in one word are not corrected. The read returns the stored data bits unchanged and `err` stays low.
- R11: With `inj_en` high at a rising edge, bit `inj_bit` of word `inj_addr` is inverted. The injection is ignored in a cycle where a write is active, and also when `inj_bit` is above 38.
- R12: After reset, every word reads as zero with `err` low.
- R13: An address at or above the array depth behaves as a deselect. A write to it stores nothing, and a read of it drives no lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for writes, injection and reset |
| rst_n | input | 1 | Active-low synchronous reset; clears the array |
| cs1_n | input | 1 | Chip select 1, active low |
| cs2_n | input | 1 | Chip select 2, active low |
| cs3_n | input | 1 | Chip select 3, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| be_n | input | 4 | Byte lane enables, active low, lane i = bits 8i+7:8i |
| addr | input | ADDR_W | Word address |
| din | input | 32 | Write data |
| dout | output | 32 | Corrected read data, zero on undriven lanes |
| dout_oe | output | 4 | Per-lane output drive enable (0 = high impedance) |
| err | output | 1 | High while a read corrects a single-bit error |
| inj_en | input | 1 | Test only: flip one stored bit at the clock edge |
| inj_addr | input | ADDR_W | Test only: word whose bit is flipped |
| inj_bit | input | 6 | Test only: codeword bit index 0-38 |

## Verification
The hardest situation to reach from the ports is a word that carries a stored fault while it also takes part in a partial write or a second read. A normal write always stores a consistent codeword, so that state cannot arise through the write path. The bench uses the injection port to flip chosen data, Hamming and parity bits in words it has just written. It then issues repeated reads to show that nothing is written back, and byte-lane writes to show that the repaired old bytes are merged in. A second injection into the same word creates the double fault that must pass through uncorrected and without a flag.

// File: rtl/ecc_mem_pkg.sv
package ecc_mem_pkg;
  localparam int DATA_W  = 32;
  localparam int HAM_W   = 6;
  localparam int WORD_W  = DATA_W + HAM_W + 1;
  localparam int LANES   = DATA_W / 8;

  typedef logic [WORD_W-1:0] word_t;

  // Hamming position of data bit j: positions from 3 upward, skipping powers of two
  function automatic logic [HAM_W-1:0] data_pos(input int j);
    int cnt;
    logic [HAM_W-1:0] r;
    cnt = 0;
    r   = '0;
    for (int p = 3; p < 64; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (cnt == j && r == '0) r = HAM_W'(p);
        cnt++;
      end
    end
    return r;
  endfunction

  // XOR of the positions of all set data bits
  function automatic logic [HAM_W-1:0] hamming(input logic [DATA_W-1:0] d);
    logic [HAM_W-1:0] r;
    r = '0;
    for (int j = 0; j < DATA_W; j++)
      if (d[j]) r ^= data_pos(j);
    return r;
  endfunction

  // Codeword layout: [31:0] data, [37:32] Hamming bits, [38] overall parity
  function automatic word_t encode(input logic [DATA_W-1:0] d);
    logic [HAM_W-1:0] h;
    h = hamming(d);
    return {^{h, d}, h, d};
  endfunction
endpackage

// File: rtl/ecc_mem_ctrl.sv
module ecc_mem_ctrl
  import ecc_mem_pkg::*;
(
  input  logic             cs1_n,
  input  logic             cs2_n,
  input  logic             cs3_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic [LANES-1:0] be_n,
  input  logic             addr_ok,
  output logic             sel,
  output logic             wr_act,
  output logic             rd_act,
  output logic [LANES-1:0] lane_oe
);
  always_comb begin
    sel     = ~cs1_n & ~cs2_n & ~cs3_n & addr_ok;
    wr_act  = sel & ~we_n;
    rd_act  = sel & we_n & ~oe_n & (be_n != '1);
    lane_oe = rd_act ? ~be_n : '0;
  end
endmodule

// File: rtl/ecc_mem_decoder.sv
module ecc_mem_decoder
  import ecc_mem_pkg::*;
(
  input  word_t             word,
  output logic [DATA_W-1:0] data_fix,
  output logic              single_evt,
  output logic              double_evt
);
  logic [HAM_W-1:0] syndrome;
  logic             parity;

  always_comb begin
    syndrome   = word[DATA_W +: HAM_W] ^ hamming(word[DATA_W-1:0]);
    parity     = ^word;
    single_evt = parity;
    double_evt = ~parity & (syndrome != '0);
    for (int j = 0; j < DATA_W; j++)
      data_fix[j] = word[j] ^ (parity & (syndrome == data_pos(j)));
  end
endmodule

// File: rtl/ecc_mem_array.sv
module ecc_mem_array
  import ecc_mem_pkg::*;
#(
  parameter int DEPTH_LOG2 = 8,
  localparam int DEPTH = 1 << DEPTH_LOG2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [DEPTH_LOG2-1:0] wr_idx,
  input  word_t                 wr_word,
  input  logic                  flip_en,
  input  logic [DEPTH_LOG2-1:0] flip_idx,
  input  word_t                 flip_mask,
  input  logic [DEPTH_LOG2-1:0] rd_idx,
  output word_t                 rd_word
);
  word_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_word;
    end else if (flip_en) begin
      mem[flip_idx] <= mem[flip_idx] ^ flip_mask;
    end
  end

  assign rd_word = mem[rd_idx];
endmodule

// File: rtl/ecc_mem.sv
module ecc_mem
  import ecc_mem_pkg::*;
#(
  parameter int ADDR_W     = 19,
  parameter int DEPTH_LOG2 = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs1_n,
  input  logic               cs2_n,
  input  logic               cs3_n,
  input  logic               we_n,
  input  logic               oe_n,
  input  logic [3:0]         be_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [31:0]        din,
  output logic [31:0]        dout,
  output logic [3:0]         dout_oe,
  output logic               err,
  input  logic               inj_en,
  input  logic [ADDR_W-1:0]  inj_addr,
  input  logic [5:0]         inj_bit
);
  localparam int LAST_BIT = WORD_W - 1;

  logic              addr_ok, inj_ok;
  logic              sel, wr_act, rd_act;
  logic [LANES-1:0]  lane_oe;
  word_t             stored, new_word, flip_mask;
  logic [DATA_W-1:0] fixed, merged;
  logic              corr_evt, dbl_evt, flip_act;

  generate
    if (DEPTH_LOG2 < ADDR_W) begin : g_range
      assign addr_ok = ~|addr[ADDR_W-1:DEPTH_LOG2];
      assign inj_ok  = ~|inj_addr[ADDR_W-1:DEPTH_LOG2];
    end else begin : g_full
      assign addr_ok = 1'b1;
      assign inj_ok  = 1'b1;
    end
  endgenerate

  ecc_mem_ctrl u_ctrl (
    .cs1_n(cs1_n), .cs2_n(cs2_n), .cs3_n(cs3_n), .we_n(we_n), .oe_n(oe_n),
    .be_n(be_n), .addr_ok(addr_ok), .sel(sel), .wr_act(wr_act),
    .rd_act(rd_act), .lane_oe(lane_oe)
  );

  ecc_mem_array #(.DEPTH_LOG2(DEPTH_LOG2)) u_array (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_act), .wr_idx(addr[DEPTH_LOG2-1:0]), .wr_word(new_word),
    .flip_en(flip_act), .flip_idx(inj_addr[DEPTH_LOG2-1:0]), .flip_mask(flip_mask),
    .rd_idx(addr[DEPTH_LOG2-1:0]), .rd_word(stored)
  );

  ecc_mem_decoder u_dec (
    .word(stored), .data_fix(fixed), .single_evt(corr_evt), .double_evt(dbl_evt)
  );

  // Lane merge for writes and lane gating for reads
  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign merged[8*i +: 8] = be_n[i] ? fixed[8*i +: 8] : din[8*i +: 8];
      assign dout[8*i +: 8]   = lane_oe[i] ? fixed[8*i +: 8] : 8'h00;
    end
  endgenerate

  assign new_word  = encode(merged);
  assign flip_mask = word_t'(1) << inj_bit;
  assign flip_act  = inj_en & inj_ok & ~wr_act & (int'(inj_bit) <= LAST_BIT);
  assign dout_oe   = lane_oe;
  assign err       = rd_act & corr_evt;
endmodule

// File: rtl/ecc_mem_chk.sv
module ecc_mem_chk #(
  parameter int ADDR_W = 19
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs1_n,
  input logic              cs2_n,
  input logic              cs3_n,
  input logic              we_n,
  input logic              oe_n,
  input logic [3:0]        be_n,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       din,
  input logic [31:0]       dout,
  input logic [3:0]        dout_oe,
  input logic              err,
  input logic              rd_act,
  input logic              wr_act,
  input logic              dbl_evt
);
  logic armed;
  logic [31:0] lane_mask;

  always_ff @(posedge clk) armed <= rst_n;

  assign lane_mask = {{8{dout_oe[3]}}, {8{dout_oe[2]}}, {8{dout_oe[1]}}, {8{dout_oe[0]}}};

  p_deselect_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cs1_n || cs2_n || cs3_n) |-> (dout_oe == 4'b0000 && !err));

  p_write_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && rd_act && be_n == 4'b0000 && $past(wr_act) && $past(be_n) == 4'b0000
     && addr == $past(addr)) |-> (dout == $past(din) && !err));

  p_lane_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_oe != 4'b0000) |-> (dout_oe == ~be_n));

  p_undriven_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dout & ~lane_mask) == 32'h0);

  p_hiz_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_n || !we_n || be_n == 4'b1111) |-> (dout_oe == 4'b0000));

  p_err_read_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> rd_act);

  p_double_no_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dbl_evt |-> !err);
endmodule

bind ecc_mem ecc_mem_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs1_n(cs1_n), .cs2_n(cs2_n), .cs3_n(cs3_n),
  .we_n(we_n), .oe_n(oe_n), .be_n(be_n), .addr(addr), .din(din),
  .dout(dout), .dout_oe(dout_oe), .err(err), .rd_act(rd_act),
  .wr_act(wr_act), .dbl_evt(dbl_evt)
);

// File: tb/ecc_mem_tb.sv
module ecc_mem_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 19;
  localparam int DEPTH_LOG2 = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cs1_n, cs2_n, cs3_n, we_n, oe_n;
  logic [3:0]        be_n;
  logic [ADDR_W-1:0] addr, inj_addr;
  logic [31:0]       din, dout;
  logic [3:0]        dout_oe;
  logic              err, inj_en;
  logic [5:0]        inj_bit;

  int checks = 0;
  int fails  = 0;
  logic [31:0] r_dout;
  logic [3:0]  r_oe;
  logic        r_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_mem #(.ADDR_W(ADDR_W), .DEPTH_LOG2(DEPTH_LOG2)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs1_n(cs1_n), .cs2_n(cs2_n), .cs3_n(cs3_n),
    .we_n(we_n), .oe_n(oe_n), .be_n(be_n), .addr(addr), .din(din),
    .dout(dout), .dout_oe(dout_oe), .err(err), .inj_en(inj_en),
    .inj_addr(inj_addr), .inj_bit(inj_bit)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    cs1_n = 1; cs2_n = 1; cs3_n = 1; we_n = 1; oe_n = 1; be_n = 4'hF;
    addr = '0; din = '0; inj_en = 0; inj_addr = '0; inj_bit = '0;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d, input logic [3:0] b);
    @(negedge clk);
    idle();
    cs1_n = 0; cs2_n = 0; cs3_n = 0; we_n = 0; be_n = b; addr = a; din = d;
    @(negedge clk);
    idle();
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [3:0] b);
    @(negedge clk);
    idle();
    cs1_n = 0; cs2_n = 0; cs3_n = 0; oe_n = 0; be_n = b; addr = a;
    #1;
    r_dout = dout; r_oe = dout_oe; r_err = err;
  endtask

  task automatic inject(input logic [ADDR_W-1:0] a, input logic [5:0] bitx);
    @(negedge clk);
    idle();
    inj_en = 1; inj_addr = a; inj_bit = bitx;
    @(negedge clk);
    idle();
  endtask

  task automatic t_reset();
    for (int a = 0; a < 4; a++) begin
      rd(ADDR_W'(a * 37), 4'h0);
      check(r_dout == 0 && !r_err && r_oe == 4'hF, "R12 reset contents", {r_err, r_oe, r_dout}, {1'b0, 4'hF, 32'h0});
    end
  endtask

  task automatic t_full_write();
    wr(19'd10, 32'hDEADBEEF, 4'h0);
    rd(19'd10, 4'h0);
    check(r_dout == 32'hDEADBEEF && !r_err, "R2 full write readback", {r_err, r_dout}, {1'b0, 32'hDEADBEEF});
    wr(19'd255, 32'h0123_4567, 4'h0);
    rd(19'd255, 4'h0);
    check(r_dout == 32'h0123_4567 && !r_err, "R2 top word readback R7", {r_err, r_dout}, {1'b0, 32'h01234567});
  endtask

  task automatic t_select();
    wr(19'd20, 32'h1111_2222, 4'h0);
    @(negedge clk);
    idle();
    cs1_n = 0; cs2_n = 1; cs3_n = 0; we_n = 0; be_n = 4'h0; addr = 19'd20; din = 32'hFFFF_FFFF;
    @(negedge clk);
    idle();
    rd(19'd20, 4'h0);
    check(r_dout == 32'h1111_2222, "R1 deselected write ignored", r_dout, 32'h11112222);
    @(negedge clk);
    idle();
    cs1_n = 0; cs2_n = 0; cs3_n = 1; oe_n = 0; be_n = 4'h0; addr = 19'd20;
    #1;
    check(dout_oe == 0 && !err, "R1 deselected read undriven", {err, dout_oe}, 5'h0);
  endtask

  task automatic t_bytes();
    wr(19'd30, 32'hAABB_CCDD, 4'h0);
    wr(19'd30, 32'h1122_3344, 4'b1010);
    rd(19'd30, 4'h0);
    check(r_dout == 32'hAA22_CC44, "R3 lanes 0 and 2 written", r_dout, 32'hAA22CC44);
    rd(19'd30, 4'b0110);
    check(r_oe == 4'b1001 && r_dout == 32'hAA00_0044, "R4 lanes 0 and 3 read", {r_oe, r_dout}, {4'b1001, 32'hAA000044});
  endtask

  task automatic t_hiz();
    rd(19'd30, 4'hF);
    check(r_oe == 0, "R5 all bytes disabled", r_oe, 0);
    @(negedge clk);
    idle();
    cs1_n = 0; cs2_n = 0; cs3_n = 0; oe_n = 1; be_n = 4'h0; addr = 19'd30;
    #1;
    check(dout_oe == 0, "R5 oe_n high", dout_oe, 0);
    we_n = 0; oe_n = 0; din = 32'hAA22_CC44;
    #1;
    check(dout_oe == 0, "R5 write active", dout_oe, 0);
    @(negedge clk);
    idle();
  endtask

  task automatic t_single();
    int bits[5] = '{0, 17, 31, 34, 38};
    foreach (bits[k]) begin
      wr(19'd40, 32'hC3A5_5A3C, 4'h0);
      rd(19'd40, 4'h0);
      check(!r_err, "R7 clean read no flag", r_err, 0);
      inject(19'd40, 6'(bits[k]));
      rd(19'd40, 4'h0);
      check(r_dout == 32'hC3A5_5A3C && r_err, "R6 single bit corrected", {r_err, r_dout}, {1'b1, 32'hC3A55A3C});
    end
    @(negedge clk);
    idle();
    #1;
    check(!err, "R7 flag low when idle", err, 0);
  endtask

  task automatic t_nowb();
    wr(19'd50, 32'h5555_AAAA, 4'h0);
    inject(19'd50, 6'd5);
    rd(19'd50, 4'h0);
    rd(19'd50, 4'h0);
    check(r_err && r_dout == 32'h5555_AAAA, "R8 second read still flags", {r_err, r_dout}, {1'b1, 32'h5555AAAA});
    wr(19'd50, 32'h5555_AAAA, 4'h0);
    rd(19'd50, 4'h0);
    check(!r_err, "R8 rewrite clears fault", r_err, 0);
  endtask

  task automatic t_merge();
    wr(19'd60, 32'h1234_5678, 4'h0);
    inject(19'd60, 6'd2);
    wr(19'd60, 32'h9900_0000, 4'b0111);
    rd(19'd60, 4'h0);
    check(r_dout == 32'h9934_5678 && !r_err, "R9 repaired merge", {r_err, r_dout}, {1'b0, 32'h99345678});
  endtask

  task automatic t_double();
    wr(19'd70, 32'h0F0F_0F0F, 4'h0);
    inject(19'd70, 6'd3);
    inject(19'd70, 6'd10);
    rd(19'd70, 4'h0);
    check(r_dout == (32'h0F0F_0F0F ^ 32'h0000_0408) && !r_err, "R10 double fault passes",
          {r_err, r_dout}, {1'b0, 32'h0F0F0B07});
  endtask

  task automatic t_inject_rules();
    wr(19'd80, 32'hCAFE_F00D, 4'h0);
    @(negedge clk);
    idle();
    cs1_n = 0; cs2_n = 0; cs3_n = 0; we_n = 0; be_n = 4'h0; addr = 19'd81; din = 32'h0;
    inj_en = 1; inj_addr = 19'd80; inj_bit = 6'd4;
    @(negedge clk);
    idle();
    rd(19'd80, 4'h0);
    check(!r_err && r_dout == 32'hCAFE_F00D, "R11 inject ignored during write", {r_err, r_dout}, {1'b0, 32'hCAFEF00D});
    inject(19'd80, 6'd40);
    rd(19'd80, 4'h0);
    check(!r_err, "R11 inject index above 38 ignored", r_err, 0);
    inject(19'd80, 6'd9);
    rd(19'd80, 4'h0);
    check(r_err, "R11 inject flips bit", r_err, 1);
  endtask

  task automatic t_range();
    wr(19'd0, 32'h7777_8888, 4'h0);
    wr(19'd256, 32'h0000_0001, 4'h0);
    rd(19'd0, 4'h0);
    check(r_dout == 32'h7777_8888, "R13 out of range write dropped", r_dout, 32'h77778888);
    rd(19'd256, 4'h0);
    check(r_oe == 0, "R13 out of range read undriven", r_oe, 0);
  endtask

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_full_write();
    t_select();
    t_bytes();
    t_hiz();
    t_single();
    t_nowb();
    t_merge();
    t_double();
    t_inject_rules();
    t_range();
    @(negedge clk);
    idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule